// File: doc/BRIEF.md
# Link Power State Controller

This block decides when a multi-lane link redriver sleeps, waits or runs. It keeps a small set of control fields that software loads with a write strobe. From these fields and the hot-plug input it chooses one of three states: power-down, standby or active. In standby only the per-lane signal-presence detectors are armed. The block moves to active once a lane that software enabled has carried signal long enough to rule out noise. Only then are the lane enable outputs driven.

The hot-plug line is passed on to the upstream side only while software allows operation. The display-data-channel buffer enable is gated by both the raw hot-plug input and the software power-down field. A low hot-plug input can force power-down unless software sets an override. A change of the link data rate while the block is active sends it back to standby, where it waits for fresh signal. A soft-reset strobe returns every control field to its default value.

Top module: `link_pwr_ctrl`

## Requirements
- R1: After reset the software power-down field is 1, the state is power-down, and no lane is enabled. While that field is 1 at a clock edge, the state is power-down after that edge.
- R2: `hotplug_out` equals `hotplug_in` while the power-down field is 0, and is 0 while it is 1.
- R3: With the hot-plug override field at 0, a `hotplug_in` low at two consecutive clock edges puts the block into power-down one edge later. A low lasting a single edge leaves the state unchanged.
- R4: With the hot-plug override field at 1, a low `hotplug_in` of any length does not leave the active state.
- R5: With the standby-skip field at 0, leaving power-down enters standby. Standby turns active on the edge after any enabled lane's `sig_present` bit has been sampled high at 4 consecutive edges. Shorter runs are ignored, and so is signal on lanes whose mask bit is 0.
- R6: With the standby-skip field at 1, power-down or standby goes to active on the next edge.
- R7: `ddc_buf_on` is 1 only while the DDC-enable field is 1, `hotplug_in` is 1 and the power-down field is 0.
- R8: `state` encodes power-down as 0, standby as 1 and active as 2. `stat_pd` is 1 exactly in power-down and `stat_stby` is 1 exactly in standby.
- R9: `lane_on` equals the lane mask field in the active state and is all zero otherwise. `sig_mon` is 1 in standby and active.
- R10: A `soft_rst` pulse restores all control fields to their defaults (power-down 1, override 0, skip 0, DDC enable 0, mask all ones), and takes priority over a `cfg_wr` in the same cycle. The strobe acts only in the cycle it is high.
- R11: With the skip field at 0, a `link_rate` value that differs from the value of the previous edge moves active to standby. With the skip field at 1, a rate change has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load all control fields from the cfg_* inputs |
| cfg_pd_force | input | 1 | Software power-down field value |
| cfg_hp_ignore | input | 1 | Hot-plug override field value |
| cfg_stby_skip | input | 1 | Standby-skip field value |
| cfg_ddc_req | input | 1 | DDC buffer enable field value |
| cfg_lane_mask | input | NUM_LANES | Per-lane enable field value |
| soft_rst | input | 1 | Restore control fields to defaults |
| hotplug_in | input | 1 | Hot-plug detect from the downstream side |
| sig_present | input | NUM_LANES | Per-lane incoming signal detect |
| link_rate | input | RATE_W | Current link data-rate code |
| state | output | 2 | Power state code |
| lane_on | output | NUM_LANES | Per-lane enable |
| sig_mon | output | 1 | Signal detectors armed |
| hotplug_out | output | 1 | Hot-plug level toward the upstream side |
| ddc_buf_on | output | 1 | DDC buffer enable |
| stat_pd | output | 1 | Power-down status |
| stat_stby | output | 1 | Standby status |

## Verification
A soft reset and a configuration write can fall in the same cycle. The bench provokes this by raising `soft_rst` together with a `cfg_wr` that clears the power-down field. It judges the result by `hotplug_out` going low at once and the state staying in power-down. A second collision is a short hot-plug glitch during the active state. The bench drives a one-edge low and checks that `hotplug_out` and `ddc_buf_on` drop at once while the state stays active.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
   typedef enum logic [1:0] {
      ST_PD   = 2'd0,
      ST_STBY = 2'd1,
      ST_ACT  = 2'd2
   } pwr_st_e;

   typedef struct packed {
      logic pd_force;
      logic hp_ignore;
      logic stby_skip;
      logic ddc_req;
   } ctl_t;

   localparam ctl_t CTL_DEFAULT = '{pd_force: 1'b1, hp_ignore: 1'b0,
                                    stby_skip: 1'b0, ddc_req: 1'b0};
endpackage

// File: rtl/lpc_ctl_regs.sv
module lpc_ctl_regs
   import lpc_pkg::*;
#(
   parameter int NUM_LANES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic                 srst,
   input  ctl_t                 wr_ctl,
   input  logic [NUM_LANES-1:0] wr_mask,
   output ctl_t                 ctl_q,
   output logic [NUM_LANES-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= CTL_DEFAULT;
         mask_q <= '1;
      end else if (srst) begin
         ctl_q  <= CTL_DEFAULT;
         mask_q <= '1;
      end else if (wr) begin
         ctl_q  <= wr_ctl;
         mask_q <= wr_mask;
      end
   end
endmodule

// File: rtl/lpc_hp_deglitch.sv
module lpc_hp_deglitch #(
   parameter int LOW_MIN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hp_in,
   output logic hp_lost
);
   localparam int CW = $clog2(LOW_MIN + 1);
   localparam logic [CW-1:0] LIM = CW'(LOW_MIN);

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             low_cnt <= '0;
      else if (hp_in)         low_cnt <= '0;
      else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
   end

   assign hp_lost = (low_cnt == LIM);
endmodule

// File: rtl/lpc_sig_qual.sv
module lpc_sig_qual #(
   parameter int NUM_LANES = 4,
   parameter int RUN_MIN   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 arm,
   input  logic [NUM_LANES-1:0] mask,
   input  logic [NUM_LANES-1:0] sig,
   output logic                 any_ok
);
   localparam int CW = $clog2(RUN_MIN + 1);
   localparam logic [CW-1:0] LIM = CW'(RUN_MIN);

   logic [NUM_LANES-1:0] ok;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic [CW-1:0] run_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           run_cnt <= '0;
         else if (!(arm && mask[l] && sig[l])) run_cnt <= '0;
         else if (run_cnt != LIM)              run_cnt <= run_cnt + 1'b1;
      end
      assign ok[l] = (run_cnt == LIM);
   end

   assign any_ok = |ok;
endmodule

// File: rtl/lpc_pwr_fsm.sv
module lpc_pwr_fsm
   import lpc_pkg::*;
#(
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd_req,
   input  logic              stby_skip,
   input  logic              sig_ok,
   input  logic [RATE_W-1:0] rate,
   output pwr_st_e           st_q
);
   logic [RATE_W-1:0] rate_q;
   pwr_st_e           st_d;
   logic              rate_chg;

   assign rate_chg = (rate != rate_q);

   always_comb begin
      st_d = st_q;
      if (pd_req) begin
         st_d = ST_PD;
      end else begin
         unique case (st_q)
            ST_PD:   st_d = stby_skip ? ST_ACT : ST_STBY;
            ST_STBY: if (stby_skip || sig_ok) st_d = ST_ACT;
            ST_ACT:  if (rate_chg && !stby_skip) st_d = ST_STBY;
            default: st_d = ST_PD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_PD;
         rate_q <= '0;
      end else begin
         st_q   <= st_d;
         rate_q <= rate;
      end
   end
endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
   import lpc_pkg::*;
#(
   parameter int NUM_LANES   = 4,
   parameter int RATE_W      = 4,
   parameter int SIG_RUN     = 4,
   parameter int HP_LOW_MIN  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic                 cfg_pd_force,
   input  logic                 cfg_hp_ignore,
   input  logic                 cfg_stby_skip,
   input  logic                 cfg_ddc_req,
   input  logic [NUM_LANES-1:0] cfg_lane_mask,
   input  logic                 soft_rst,
   input  logic                 hotplug_in,
   input  logic [NUM_LANES-1:0] sig_present,
   input  logic [RATE_W-1:0]    link_rate,
   output logic [1:0]           state,
   output logic [NUM_LANES-1:0] lane_on,
   output logic                 sig_mon,
   output logic                 hotplug_out,
   output logic                 ddc_buf_on,
   output logic                 stat_pd,
   output logic                 stat_stby
);
   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("NUM_LANES must be at least 1");
   end
   if (RATE_W < 1) begin : g_bad_rate
      $error("RATE_W must be at least 1");
   end
   if (SIG_RUN < 1) begin : g_bad_run
      $error("SIG_RUN must be at least 1");
   end
   if (HP_LOW_MIN < 1) begin : g_bad_low
      $error("HP_LOW_MIN must be at least 1");
   end

   ctl_t                 wr_ctl, ctl_q;
   logic [NUM_LANES-1:0] mask_q;
   logic                 hp_lost, sig_ok, pd_req;
   pwr_st_e              st_q;
   logic                 pd_force_w, hp_ignore_w;

   assign wr_ctl = '{pd_force: cfg_pd_force, hp_ignore: cfg_hp_ignore,
                     stby_skip: cfg_stby_skip, ddc_req: cfg_ddc_req};

   lpc_ctl_regs #(.NUM_LANES(NUM_LANES)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cfg_wr),
      .srst    (soft_rst),
      .wr_ctl  (wr_ctl),
      .wr_mask (cfg_lane_mask),
      .ctl_q   (ctl_q),
      .mask_q  (mask_q)
   );

   lpc_hp_deglitch #(.LOW_MIN(HP_LOW_MIN)) u_hp (
      .clk     (clk),
      .rst_n   (rst_n),
      .hp_in   (hotplug_in),
      .hp_lost (hp_lost)
   );

   lpc_sig_qual #(.NUM_LANES(NUM_LANES), .RUN_MIN(SIG_RUN)) u_sig (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (st_q == ST_STBY),
      .mask   (mask_q),
      .sig    (sig_present),
      .any_ok (sig_ok)
   );

   assign pd_req = ctl_q.pd_force || (!ctl_q.hp_ignore && hp_lost);

   lpc_pwr_fsm #(.RATE_W(RATE_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .pd_req    (pd_req),
      .stby_skip (ctl_q.stby_skip),
      .sig_ok    (sig_ok),
      .rate      (link_rate),
      .st_q      (st_q)
   );

   assign pd_force_w  = ctl_q.pd_force;
   assign hp_ignore_w = ctl_q.hp_ignore;

   assign state       = st_q;
   assign lane_on     = (st_q == ST_ACT) ? mask_q : '0;
   assign sig_mon     = (st_q != ST_PD);
   assign hotplug_out = hotplug_in && !ctl_q.pd_force;
   assign ddc_buf_on  = ctl_q.ddc_req && hotplug_in && !ctl_q.pd_force;
   assign stat_pd     = (st_q == ST_PD);
   assign stat_stby   = (st_q == ST_STBY);
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker #(
   parameter int NUM_LANES = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 hotplug_in,
   input logic                 hotplug_out,
   input logic                 ddc_buf_on,
   input logic [1:0]           state,
   input logic [NUM_LANES-1:0] lane_on,
   input logic                 pd_force,
   input logic                 hp_ignore
);
   // R1
   pd_field_forces_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pd_force |=> (state == 2'd0));

   // R2
   hp_out_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pd_force |-> !hotplug_out);

   // R3
   hp_loss_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hp_ignore && !hotplug_in && !$past(hotplug_in)) |=> ##1 (state == 2'd0));

   // R7
   ddc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hotplug_in || pd_force) |-> !ddc_buf_on);

   // R9
   lanes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != 2'd2) |-> (lane_on == '0));
endmodule

bind link_pwr_ctrl lpc_checker #(.NUM_LANES(NUM_LANES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hotplug_in  (hotplug_in),
   .hotplug_out (hotplug_out),
   .ddc_buf_on  (ddc_buf_on),
   .state       (state),
   .lane_on     (lane_on),
   .pd_force    (pd_force_w),
   .hp_ignore   (hp_ignore_w)
);

// File: tb/tb_link_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_link_pwr_ctrl;
   localparam int N = 4;
   localparam int RW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic          cfg_pd_force = 1'b0, cfg_hp_ignore = 1'b0;
   logic          cfg_stby_skip = 1'b0, cfg_ddc_req = 1'b0;
   logic [N-1:0]  cfg_lane_mask = '0;
   logic          soft_rst = 1'b0;
   logic          hotplug_in = 1'b1;
   logic [N-1:0]  sig_present = '0;
   logic [RW-1:0] link_rate = '0;
   logic [1:0]    state;
   logic [N-1:0]  lane_on;
   logic          sig_mon, hotplug_out, ddc_buf_on, stat_pd, stat_stby;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   link_pwr_ctrl #(.NUM_LANES(N), .RATE_W(RW)) dut (.*);

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg(input logic pd, input logic ign, input logic skip,
                      input logic ddc, input logic [N-1:0] msk);
      cfg_pd_force = pd; cfg_hp_ignore = ign; cfg_stby_skip = skip;
      cfg_ddc_req = ddc; cfg_lane_mask = msk; cfg_wr = 1'b1;
      tick(1);
      cfg_wr = 1'b0;
   endtask

   task automatic t_reset();
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R1 state", state, 0);
      chk("R1 lane_on", lane_on, 0);
      chk("R8 stat_pd", stat_pd, 1);
      chk("R8 stat_stby", stat_stby, 0);
      chk("R2 hotplug_out", hotplug_out, 0);
      chk("R9 sig_mon", sig_mon, 0);
   endtask

   task automatic t_standby_entry();
      cfg(0, 0, 0, 1, 4'hF);
      chk("R1 state on write edge", state, 0);
      chk("R2 hotplug_out", hotplug_out, 1);
      tick(1);
      chk("R5 standby", state, 1);
      chk("R8 stat_stby", stat_stby, 1);
      chk("R8 stat_pd", stat_pd, 0);
      chk("R9 lane_on", lane_on, 0);
      chk("R9 sig_mon", sig_mon, 1);
      chk("R7 ddc_buf_on", ddc_buf_on, 1);
   endtask

   task automatic t_sig_filter();
      sig_present = 4'h1; tick(3);
      sig_present = 4'h0; tick(2);
      chk("R5 short run", state, 1);
      cfg(0, 0, 0, 1, 4'hE);
      sig_present = 4'h1; tick(6);
      chk("R5 masked lane", state, 1);
      sig_present = 4'h4; tick(4);
      chk("R5 before qualify", state, 1);
      tick(1);
      chk("R5 active", state, 2);
      chk("R9 lane_on mask", lane_on, 4'hE);
      chk("R8 stat_pd", stat_pd, 0);
      chk("R8 stat_stby", stat_stby, 0);
      sig_present = 4'h0;
   endtask

   task automatic t_hp_glitch();
      hotplug_in = 1'b0; #1;
      chk("R2 hotplug_out follows", hotplug_out, 0);
      chk("R7 ddc off on low", ddc_buf_on, 0);
      tick(1);
      hotplug_in = 1'b1;
      tick(3);
      chk("R3 glitch ignored", state, 2);
      chk("R7 ddc back", ddc_buf_on, 1);
   endtask

   task automatic t_hp_loss();
      hotplug_in = 1'b0;
      tick(2);
      chk("R3 not yet", state, 2);
      tick(1);
      chk("R3 power-down", state, 0);
      chk("R9 lane_on off", lane_on, 0);
      hotplug_in = 1'b1;
      tick(1);
      chk("R3 still down", state, 0);
      tick(1);
      chk("R5 re-standby", state, 1);
   endtask

   task automatic t_ignore();
      cfg(0, 1, 1, 1, 4'hF);
      tick(1);
      chk("R6 standby skip", state, 2);
      chk("R9 lane_on all", lane_on, 4'hF);
      hotplug_in = 1'b0;
      tick(5);
      chk("R4 stays active", state, 2);
      chk("R7 ddc off", ddc_buf_on, 0);
      hotplug_in = 1'b1;
      tick(1);
   endtask

   task automatic t_direct();
      cfg(1, 1, 1, 1, 4'hF);
      tick(1);
      chk("R1 forced down", state, 0);
      chk("R2 hotplug_out low", hotplug_out, 0);
      chk("R7 ddc off", ddc_buf_on, 0);
      cfg(0, 1, 1, 1, 4'hF);
      chk("R6 on write edge", state, 0);
      tick(1);
      chk("R6 direct active", state, 2);
   endtask

   task automatic t_rate();
      cfg(0, 1, 0, 1, 4'hF);
      tick(1);
      chk("R11 no change", state, 2);
      link_rate = 4'd5;
      tick(1);
      chk("R11 back to standby", state, 1);
      chk("R9 lane_on off", lane_on, 0);
      tick(3);
      chk("R11 holds standby", state, 1);
      cfg(0, 1, 1, 1, 4'hF);
      tick(1);
      chk("R6 active", state, 2);
      link_rate = 4'd6;
      tick(2);
      chk("R11 ignored with skip", state, 2);
   endtask

   task automatic t_soft_rst();
      cfg_pd_force = 0; cfg_hp_ignore = 1; cfg_stby_skip = 1;
      cfg_ddc_req = 1; cfg_lane_mask = 4'h3;
      cfg_wr = 1'b1; soft_rst = 1'b1;
      tick(1);
      cfg_wr = 1'b0; soft_rst = 1'b0;
      chk("R10 pd default", hotplug_out, 0);
      chk("R10 ddc default", ddc_buf_on, 0);
      tick(1);
      chk("R10 state down", state, 0);
      cfg(0, 0, 0, 1, 4'hF);
      tick(1);
      chk("R10 pulse only", state, 1);
   endtask

   initial begin
      t_reset();
      t_standby_entry();
      t_sig_filter();
      t_hp_glitch();
      t_hp_loss();
      t_ignore();
      t_direct();
      t_rate();
      t_soft_rst();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 50000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule